// File: doc/BRIEF.md
# Transmit Descriptor Ring Drainer

This block walks a ring of transmit descriptors in shared memory and sends out every frame that software has marked ready. A one-cycle trigger pulse, sent after each host register write, starts a scan, unless the controller's stop flag is set. A scan begins at the saved ring index and visits the following entries in order. For each entry whose control byte says "hardware-owned, whole frame", the block does three things:

- It reads the frame length, which is stored as a negative number.
- It fetches the frame buffer one 16-bit word at a time and streams the bytes out on a valid/ready port.
- It writes the control byte back to hand the entry to software.

Each sent frame moves the saved index forward by one and pulses the transmit event flags. Once the scan is over, the block makes a single interrupt decision from the enable bit, the summary bit and whether the scan sent anything.

Each descriptor is four 16-bit words at `ring_base + 4*index`:

| Word | Contents |
|------|----------|
| 0 | Low 16 bits of the buffer word address |
| 1 | Bits [7:0] hold the control byte; bits [15:8] hold the high 8 bits of the buffer address |
| 2 | The negated byte count |

The memory port works in words. A request is held until it is acknowledged, and read data is taken in the acknowledge cycle.

Top module: `tdr_ring_drainer`

## Requirements
- R1: After reset the block is idle: `busy`, `tx_valid`, `mem_req` and `irq_req` are 0, and the saved ring index is 0.
- R2: A `scan_req` pulse while idle starts a scan. While `ctl_stop` is 1, a pulse makes no memory access, produces no output and is not remembered.
- R3: A scan visits 15 entries, from the saved index upward modulo 16. The entry just below the starting index is never visited in that scan.
- R4: A descriptor is sent only if its control byte (word 1, bits [7:0]) equals exactly 0x83. Any other value is skipped and that descriptor is left unwritten.
- R5: The byte count is the two's-complement negation of word 2. Bytes are read from word address `{word1[15:8], word0}` upward, low byte of each word first.
- R6: `tx_last` is 1 only on the final byte of each frame. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold.
- R7: After a frame is sent, word 1 is written as `{word1[15:8], 8'h03}`, and the saved index advances by one, wrapping modulo 16.
- R8: `ev_tint` and `ev_intr` each pulse for one cycle per sent frame.
- R9: At the end of every scan, `irq_req` pulses for one cycle if `ctl_inea` is 1 and either `ctl_intr` is 1 or the scan sent at least one frame.
- R10: Any number of `scan_req` pulses arriving during a scan cause exactly one further scan. This includes a pulse in the cycle in which the interrupt decision is made.
- R11: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_addr` and `mem_we` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_req | input | 1 | One-cycle pulse after each register write |
| ctl_stop | input | 1 | Controller stop flag |
| ctl_inea | input | 1 | Interrupt enable flag |
| ctl_intr | input | 1 | Current interrupt summary flag |
| ring_base | input | 24 | Word address of descriptor 0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 24 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 16 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Output byte accepted |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| ev_tint | output | 1 | Transmit event set pulse |
| ev_intr | output | 1 | Interrupt summary set pulse |
| irq_req | output | 1 | End-of-scan interrupt pulse |
| busy | output | 1 | Scan in progress |

## Verification
The end-of-scan interrupt decision and the arrival of a new trigger can land in the same cycle. If that pulse were lost, the frame sitting just below the old start index would be stranded until the next register write. The bench waits until it sees `irq_req` high between clock edges and raises `scan_req` for that very edge. It has prepared two ready entries, at the saved index and the one just below it. It then expects both frames to be sent across two scans and two interrupt pulses, with both control bytes rewritten.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int HI_W       = 8;
    localparam int ADDR_W     = HI_W + WORD_W;
    localparam int DESC_SHIFT = 2;

    localparam logic [1:0] OFS_BUF = 2'd0;
    localparam logic [1:0] OFS_CTL = 2'd1;
    localparam logic [1:0] OFS_LEN = 2'd2;

    localparam logic [BYTE_W-1:0] CTL_READY = 8'h83;
    localparam logic [BYTE_W-1:0] CTL_SENT  = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_RD_LEN,
        ST_RD_BUF,
        ST_STREAM,
        ST_WR_CTL,
        ST_NEXT,
        ST_DONE
    } drain_state_e;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [WORD_W-1:0] count;
    } frame_ctx_t;

    function automatic logic [WORD_W-1:0] neg_len_to_count(input logic [WORD_W-1:0] v);
        return (~v) + 16'd1;
    endfunction

    function automatic logic [ADDR_W-1:0] desc_word_addr(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] idx,
        input logic [1:0]        ofs);
        return base + (idx << DESC_SHIFT) + ADDR_W'(ofs);
    endfunction

endpackage

// File: rtl/tdr_ring_index.sv
module tdr_ring_index #(
    parameter int RING_LOG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_begin,
    input  logic                step,
    input  logic                frame_sent,
    output logic [RING_LOG-1:0] saved_idx,
    output logic [RING_LOG-1:0] scan_idx,
    output logic                final_visit
);
    localparam int RING_N = 1 << RING_LOG;
    localparam int VISITS = RING_N - 1;

    logic [RING_LOG-1:0] visit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_idx <= '0;
            scan_idx  <= '0;
            visit_q   <= '0;
        end else begin
            if (scan_begin) begin
                scan_idx <= saved_idx;
                visit_q  <= '0;
            end else if (step) begin
                scan_idx <= scan_idx + 1'b1;
                visit_q  <= visit_q + 1'b1;
            end
            if (frame_sent) begin
                saved_idx <= saved_idx + 1'b1;
            end
        end
    end

    assign final_visit = (visit_q == RING_LOG'(VISITS - 1));

    // R3: the scan never steps past its 15th visit
    p_window_r3: assert property (@(posedge clk) disable iff (rst)
        step |-> (visit_q < RING_LOG'(VISITS - 1)));

endmodule

// File: rtl/tdr_byte_feed.sv
module tdr_byte_feed
    import tdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_count,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              out_ready,
    output logic              need_word,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              drained
);
    logic [WORD_W-1:0] remain_q;
    logic [WORD_W-1:0] word_q;
    logic              have_q;
    logic              hi_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q   <= '0;
            fetch_addr <= '0;
            word_q     <= '0;
            have_q     <= 1'b0;
            hi_sel_q   <= 1'b0;
        end else if (load) begin
            remain_q   <= load_count;
            fetch_addr <= load_addr;
            have_q     <= 1'b0;
            hi_sel_q   <= 1'b0;
        end else if (word_valid && need_word) begin
            word_q <= word_data;
            have_q <= 1'b1;
        end else if (have_q && out_ready) begin
            remain_q <= remain_q - 1'b1;
            if (hi_sel_q || remain_q == 16'd1) begin
                have_q     <= 1'b0;
                hi_sel_q   <= 1'b0;
                fetch_addr <= fetch_addr + 1'b1;
            end else begin
                hi_sel_q <= 1'b1;
            end
        end
    end

    assign need_word = (remain_q != '0) && !have_q;
    assign drained   = (remain_q == '0);
    assign out_valid = have_q;
    assign out_data  = hi_sel_q ? word_q[15:8] : word_q[7:0];
    assign out_last  = have_q && (remain_q == 16'd1);

    // R6: a byte is offered only while bytes remain
    p_valid_count_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !drained);
    // R6: accepting the marked byte ends the frame
    p_last_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && !load) |=> drained);

endmodule

// File: rtl/tdr_ring_drainer.sv
module tdr_ring_drainer
    import tdr_pkg::*;
#(
    parameter int RING_LOG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_req,
    input  logic              ctl_stop,
    input  logic              ctl_inea,
    input  logic              ctl_intr,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last,
    output logic              ev_tint,
    output logic              ev_intr,
    output logic              irq_req,
    output logic              busy
);
    drain_state_e        state_q;
    frame_ctx_t          ctx_q;
    logic                sent_any_q;
    logic                pending_q;

    logic                scan_begin;
    logic                step;
    logic                frame_sent;
    logic [RING_LOG-1:0] saved_idx;
    logic [RING_LOG-1:0] scan_idx;
    logic                final_visit;

    logic                feed_load;
    logic                feed_need;
    logic [ADDR_W-1:0]   feed_addr;
    logic                feed_drained;
    logic                rerun;

    tdr_ring_index #(.RING_LOG(RING_LOG)) u_index (
        .clk         (clk),
        .rst         (rst),
        .scan_begin  (scan_begin),
        .step        (step),
        .frame_sent  (frame_sent),
        .saved_idx   (saved_idx),
        .scan_idx    (scan_idx),
        .final_visit (final_visit)
    );

    tdr_byte_feed u_feed (
        .clk        (clk),
        .rst        (rst),
        .load       (feed_load),
        .load_count (ctx_q.count),
        .load_addr  ({ctx_q.hi, mem_rdata}),
        .word_valid (state_q == ST_STREAM && mem_ack),
        .word_data  (mem_rdata),
        .out_ready  (tx_ready),
        .need_word  (feed_need),
        .fetch_addr (feed_addr),
        .out_valid  (tx_valid),
        .out_data   (tx_data),
        .out_last   (tx_last),
        .drained    (feed_drained)
    );

    assign rerun      = (pending_q || scan_req) && !ctl_stop;
    assign scan_begin = ((state_q == ST_IDLE) && scan_req && !ctl_stop) ||
                        ((state_q == ST_DONE) && rerun);
    assign step       = (state_q == ST_NEXT) && !final_visit;
    assign frame_sent = (state_q == ST_WR_CTL) && mem_ack;
    assign feed_load  = (state_q == ST_RD_BUF) && mem_ack;

    assign busy    = (state_q != ST_IDLE);
    assign ev_tint = frame_sent;
    assign ev_intr = frame_sent;
    assign irq_req = (state_q == ST_DONE) && ctl_inea && (ctl_intr || sent_any_q);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = {ctx_q.hi, CTL_SENT};
        unique case (state_q)
            ST_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_word_addr(ring_base, ADDR_W'(scan_idx), OFS_CTL);
            end
            ST_RD_LEN: begin
                mem_req  = 1'b1;
                mem_addr = desc_word_addr(ring_base, ADDR_W'(scan_idx), OFS_LEN);
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_word_addr(ring_base, ADDR_W'(scan_idx), OFS_BUF);
            end
            ST_STREAM: begin
                mem_req  = feed_need;
                mem_addr = feed_addr;
            end
            ST_WR_CTL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = desc_word_addr(ring_base, ADDR_W'(scan_idx), OFS_CTL);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ctx_q      <= '0;
            sent_any_q <= 1'b0;
            pending_q  <= 1'b0;
        end else begin
            if (state_q != ST_IDLE && state_q != ST_DONE && scan_req) begin
                pending_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    pending_q <= 1'b0;
                    if (scan_begin) begin
                        sent_any_q <= 1'b0;
                        state_q    <= ST_RD_CTL;
                    end
                end
                ST_RD_CTL: begin
                    if (mem_ack) begin
                        ctx_q.hi <= mem_rdata[15:8];
                        state_q  <= (mem_rdata[7:0] == CTL_READY) ? ST_RD_LEN : ST_NEXT;
                    end
                end
                ST_RD_LEN: begin
                    if (mem_ack) begin
                        ctx_q.count <= neg_len_to_count(mem_rdata);
                        state_q     <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: begin
                    if (mem_ack) state_q <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (feed_drained) state_q <= ST_WR_CTL;
                end
                ST_WR_CTL: begin
                    if (mem_ack) begin
                        sent_any_q <= 1'b1;
                        state_q    <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    state_q <= final_visit ? ST_DONE : ST_RD_CTL;
                end
                ST_DONE: begin
                    pending_q <= 1'b0;
                    if (rerun) begin
                        sent_any_q <= 1'b0;
                        state_q    <= ST_RD_CTL;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: nothing moves while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!tx_valid && !mem_req && !irq_req));
    // R2: a stopped controller stays idle
    p_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctl_stop) |=> !busy);
    // R6: offered byte holds until taken
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R8: one event pulse per hand-back, never back to back
    p_tint_r8: assert property (@(posedge clk) disable iff (rst)
        ev_tint |=> !ev_tint);
    // R9: the interrupt only fires when enabled
    p_irq_en_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ctl_inea);
    // R11: a memory request holds until accepted
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/tdr_ring_drainer_tb.sv
module tdr_ring_drainer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RING_N     = 16;
    localparam int MEM_WORDS  = 4096;
    localparam int RING_AT    = 'h100;
    localparam int BUF_AT     = 'h400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_req = 1'b0;
    logic        ctl_stop = 1'b0;
    logic        ctl_inea = 1'b0;
    logic        ctl_intr = 1'b0;
    logic [23:0] ring_base = 24'(RING_AT);
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_ready = 1'b0, tx_last;
    logic [7:0]  tx_data;
    logic        ev_tint, ev_intr, irq_req, busy;

    tdr_ring_drainer u_dut (
        .clk(clk), .rst(rst), .scan_req(scan_req), .ctl_stop(ctl_stop),
        .ctl_inea(ctl_inea), .ctl_intr(ctl_intr), .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .ev_tint(ev_tint), .ev_intr(ev_intr),
        .irq_req(irq_req), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] mem [0:MEM_WORDS-1];
    logic [15:0] sh_w1 [0:RING_N-1];
    logic [7:0]  exp_b[$], got_b[$];
    bit          exp_l[$], got_l[$];
    int checks = 0, failures = 0;
    int m_ptr = 0, exp_irq = 0, exp_frames = 0;
    int tint_n = 0, intr_n = 0, irq_n = 0, busy_n = 0, memreq_n = 0;
    int hold_mem_err = 0, hold_tx_err = 0;
    bit done_flag = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // memory responder, output sink and observers
    initial begin
        bit          pw = 0, pv = 0;
        logic [23:0] pa = '0;
        logic        pwe = 0;
        logic [7:0]  pd = '0;
        logic        pl = 0;
        forever begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
            if (mem_req && ($urandom % 2) == 1) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
                else mem_rdata = mem[mem_addr[11:0]];
            end else begin
                mem_ack = 1'b0;
            end
            #1;
            if (pw && !(mem_req && mem_addr == pa && mem_we == pwe)) hold_mem_err++;
            pw = mem_req && !mem_ack; pa = mem_addr; pwe = mem_we;
            if (pv && !(tx_valid && tx_data == pd && tx_last == pl)) hold_tx_err++;
            pv = tx_valid && !tx_ready; pd = tx_data; pl = tx_last;
            if (tx_valid && tx_ready) begin got_b.push_back(tx_data); got_l.push_back(tx_last); end
            if (ev_tint) tint_n++;
            if (ev_intr) intr_n++;
            if (irq_req) irq_n++;
            if (busy) busy_n++;
            if (mem_req) memreq_n++;
        end
    end

    function automatic int w1_at(int i);
        return RING_AT + i * 4 + 1;
    endfunction

    task automatic set_desc(int i, logic [7:0] ctl, int len, logic [7:0] hi);
        int base = BUF_AT + i * 'h40;
        mem[RING_AT + i*4]     = 16'(base);
        mem[w1_at(i)]          = {hi, ctl};
        mem[RING_AT + i*4 + 2] = 16'(-len);
        for (int w = 0; w < 32; w++) mem[base + w] = 16'($urandom);
    endtask

    task automatic snapshot();
        for (int i = 0; i < RING_N; i++) sh_w1[i] = mem[w1_at(i)];
    endtask

    // reference scan built from the requirements
    task automatic model_scan();
        int start = m_ptr;
        bit sent = 0;
        for (int k = 0; k < RING_N - 1; k++) begin
            int i = (start + k) % RING_N;
            if (sh_w1[i][7:0] == 8'h83) begin
                int n = int'(16'(-mem[RING_AT + i*4 + 2]));
                int base = int'({sh_w1[i][15:8], mem[RING_AT + i*4]}) % MEM_WORDS;
                for (int b = 0; b < n; b++) begin
                    logic [15:0] w = mem[(base + b/2) % MEM_WORDS];
                    exp_b.push_back((b % 2) ? w[15:8] : w[7:0]);
                    exp_l.push_back(b == n - 1);
                end
                sh_w1[i] = {sh_w1[i][15:8], 8'h03};
                m_ptr = (m_ptr + 1) % RING_N;
                exp_frames++;
                sent = 1;
            end
        end
        if (ctl_inea && (ctl_intr || sent)) exp_irq++;
    endtask

    task automatic clear_obs();
        exp_b.delete(); got_b.delete(); exp_l.delete(); got_l.delete();
        exp_irq = 0; exp_frames = 0; tint_n = 0; intr_n = 0; irq_n = 0;
        busy_n = 0; memreq_n = 0;
    endtask

    task automatic pulse();
        @(negedge clk); scan_req = 1'b1;
        @(negedge clk); scan_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 20000);
        repeat (2) @(negedge clk);
    endtask

    task automatic judge(string tag);
        bit ok = (got_b.size() == exp_b.size());
        bit okl = (got_l.size() == exp_l.size());
        int bad = 0;
        if (ok) foreach (exp_b[j]) if (got_b[j] !== exp_b[j]) ok = 0;
        if (okl) foreach (exp_l[j]) if (got_l[j] !== exp_l[j]) okl = 0;
        chk(ok, "R5", {tag, " byte stream (size)"}, got_b.size(), exp_b.size());
        chk(okl, "R6", {tag, " last markers (size)"}, got_l.size(), exp_l.size());
        for (int i = 0; i < RING_N; i++) if (mem[w1_at(i)] !== sh_w1[i]) bad++;
        chk(bad == 0, "R4/R7", {tag, " control words wrong"}, bad, 0);
        chk(tint_n == exp_frames, "R8", {tag, " tint pulses"}, tint_n, exp_frames);
        chk(intr_n == exp_frames, "R8", {tag, " intr pulses"}, intr_n, exp_frames);
        chk(irq_n == exp_irq, "R9", {tag, " irq pulses"}, irq_n, exp_irq);
        clear_obs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int a = 0; a < MEM_WORDS; a++) mem[a] = '0;
        for (int i = 0; i < RING_N; i++) set_desc(i, 8'h03, 4, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(!busy, "R1", "busy after reset", busy, 0);
        chk(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);
        chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
        chk(!irq_req, "R1", "irq_req after reset", irq_req, 0);
        clear_obs();

        // R3 + R10: window excludes entry 15 on first pass; extra pulses collapse into one rerun
        set_desc(2, 8'h83, 5, 8'h21);
        set_desc(15, 8'h83, 1, 8'h7e);
        ctl_inea = 1; ctl_intr = 0;
        snapshot(); model_scan(); model_scan();
        pulse();
        repeat (3) @(negedge clk);
        scan_req = 1; @(negedge clk); scan_req = 0; @(negedge clk);
        scan_req = 1; @(negedge clk); scan_req = 0;
        wait_idle();
        judge("R3/R10 window and rerun");

        // R2: stopped controller ignores the pulse
        set_desc(5, 8'h83, 9, 8'h00);
        ctl_stop = 1;
        pulse();
        repeat (20) @(negedge clk);
        chk(busy_n == 0, "R2", "busy cycles while stopped", busy_n, 0);
        chk(memreq_n == 0, "R2", "memory requests while stopped", memreq_n, 0);
        chk(got_b.size() == 0, "R2", "bytes while stopped", got_b.size(), 0);
        chk(mem[w1_at(5)][7:0] == 8'h83, "R2", "descriptor kept", int'(mem[w1_at(5)][7:0]), 'h83);
        ctl_stop = 0;
        clear_obs();
        set_desc(5, 8'h03, 9, 8'h00);

        // R10: trigger in the same cycle as the interrupt decision
        begin
            int p = m_ptr;
            set_desc(p, 8'h83, 7, 8'h11);
            set_desc((p + RING_N - 1) % RING_N, 8'h83, 4, 8'h22);
            ctl_inea = 1; ctl_intr = 0;
            snapshot(); model_scan(); model_scan();
            pulse();
            begin
                int n = 0;
                do begin @(negedge clk); #2; n++; end while (!irq_req && n < 20000);
            end
            scan_req = 1;
            @(negedge clk); scan_req = 0;
            wait_idle();
            judge("R10 coincident trigger");
        end

        // random rounds: R4 R5 R6 R7 R8 R9
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < RING_N; i++) begin
                logic [7:0] c;
                case ($urandom % 8)
                    0: c = 8'h82; 1: c = 8'h81; 2: c = 8'h87; 3: c = 8'hC3;
                    default: c = 8'h83;
                endcase
                if (($urandom % 4) == 0) c = 8'h03;
                set_desc(i, c, 1 + ($urandom % 60), 8'($urandom));
            end
            ctl_inea = 1'($urandom); ctl_intr = 1'($urandom);
            snapshot(); model_scan();
            pulse();
            wait_idle();
            judge($sformatf("random round %0d", r));
        end

        chk(hold_mem_err == 0, "R11", "memory request changed before ack", hold_mem_err, 0);
        chk(hold_tx_err == 0, "R6", "output byte changed before ready", hold_tx_err, 0);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule